// File: doc/BRIEF.md
# Two-Stage Pipelined Byte ALU with Status Flags

This block is a clocked arithmetic-logic unit for an 8-bit datapath. Each cycle it accepts two operands and a 4-bit operation code. It captures them on the rising clock edge and, one edge later, presents a registered result with carry, overflow and zero flags. A new operation may be issued on every cycle, so the unit works as a two-deep pipeline. The operations are sixteen in all:
- arithmetic: add, subtract, compare, increment and decrement of either operand, and multiply
- bitwise: AND, OR, XOR, and inversion of either operand
- rotation left or right by a variable distance
- a conditional clear

A synchronous clear input empties the pipeline and zeroes the outputs. It also serves as the block's initialisation: the surrounding logic holds it high until the unit is needed. Some operations leave the result, or the result and the flags, unchanged. This lets a caller test operands without disturbing the value already on the result port.

Top module: `pipe_alu`

## Requirements
- R1: Opcode 0 gives A+B and opcode 3 gives A−B, both modulo 256. Carry is the carry out for add and the borrow (A<B unsigned) for subtract. Overflow is two's-complement signed overflow.
- R2: Opcodes 1 and 2 give A+1 and B+1, with carry and overflow as for add. Opcodes 8 and 9 give A−1 and B−1, with borrow and overflow as for subtract.
- R3: Opcode 4 (compare) sets carry, overflow and zero exactly as subtract would, and leaves the result unchanged.
- R4: Opcode 10 gives the low 8 bits of the unsigned product A×B. Carry is set when the high 8 bits are nonzero. Overflow is cleared.
- R5: Opcode 5 rotates A left, and opcode 6 rotates A right, by B[2:0] positions. B[7:3] has no effect.
- R6: Opcode 11 gives ~A and opcode 15 gives ~B. Opcodes 12, 13 and 14 give A&B, A|B and A^B. Rotations and these operations clear carry and overflow.
- R7: Whenever the flags are written, zero is set exactly when the 8-bit outcome of the operation is 0.
- R8: Opcode 7 (conditional clear), when A equals B, sets the result to 0 and zero to 1, and clears carry and overflow. When A differs from B, the result and all flags keep their previous values.
- R9: Operands and opcode are taken at clock edge k. The result and flags change at edge k+1. Back-to-back issue on every cycle is supported.
- R10: At every edge where clr is 1, the result and all flags become 0 and the captured operation is discarded. This takes priority over an operation that would complete at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous pipeline clear, active high |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand; low 3 bits give the rotation distance |
| opSel | input | 4 | Operation code |
| result | output | 8 | Registered result |
| carry | output | 1 | Carry or borrow flag |
| overflow | output | 1 | Signed overflow flag |
| zero | output | 1 | Zero flag |

## Verification
The two events that can fall on one edge are a pipeline clear and an operation leaving the second stage. The bench issues an addition and raises clr on the very edge at which that sum would be written. The result must read 0, not the sum. The bench then lowers clr together with a fresh addition. It judges the R9 latency by seeing 0 one cycle later and the new sum only on the following cycle. A compare that follows must alter the flags alone. The sweep applies every opcode across all 256 values of A and nine chosen values of B, against an arithmetic model kept in the bench, with hold operations interleaved.

// File: rtl/pipe_alu_pkg.sv
package pipe_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_INCA = 4'd1,
    OP_INCB = 4'd2,
    OP_SUB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_ROL  = 4'd5,
    OP_ROR  = 4'd6,
    OP_CLRQ = 4'd7,
    OP_DECA = 4'd8,
    OP_DECB = 4'd9,
    OP_MUL  = 4'd10,
    OP_CPLA = 4'd11,
    OP_AND  = 4'd12,
    OP_OR   = 4'd13,
    OP_XOR  = 4'd14,
    OP_CPLB = 4'd15
  } aluOp_e;

  // strobes from the control stage to the datapath
  typedef struct packed {
    logic   valid;    // stage holds a live operation
    aluOp_e op;       // operation in stage two
    logic   wrY;      // result register is written
    logic   wrFlags;  // flags are written unconditionally
    logic   condClr;  // conditional clear on operand equality
    logic   arith;    // shared adder supplies the outcome
    logic   subMode;  // adder subtracts
    logic   pickB;    // adder left input is B instead of A
    logic   addOne;   // adder right input is the constant one
  } aluCtrl_t;

endpackage

// File: rtl/pipe_alu_ctrl.sv
module pipe_alu_ctrl
  import pipe_alu_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           clr,
  input  logic [OPW-1:0] opIn,
  output aluCtrl_t       ctrl
);

  aluOp_e opQ;
  logic   validQ;

  always_ff @(posedge clk) begin
    if (clr) begin
      validQ <= 1'b0;
      opQ    <= OP_ADD;
    end else begin
      validQ <= 1'b1;
      opQ    <= aluOp_e'(opIn);
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.valid   = validQ;
    ctrl.op      = opQ;
    ctrl.wrY     = 1'b1;
    ctrl.wrFlags = 1'b1;
    unique case (opQ)
      OP_ADD:  ctrl.arith = 1'b1;
      OP_INCA: begin ctrl.arith = 1'b1; ctrl.addOne = 1'b1; end
      OP_INCB: begin ctrl.arith = 1'b1; ctrl.addOne = 1'b1; ctrl.pickB = 1'b1; end
      OP_SUB:  begin ctrl.arith = 1'b1; ctrl.subMode = 1'b1; end
      OP_CMP:  begin ctrl.arith = 1'b1; ctrl.subMode = 1'b1; ctrl.wrY = 1'b0; end
      OP_DECA: begin ctrl.arith = 1'b1; ctrl.subMode = 1'b1; ctrl.addOne = 1'b1; end
      OP_DECB: begin
        ctrl.arith   = 1'b1;
        ctrl.subMode = 1'b1;
        ctrl.addOne  = 1'b1;
        ctrl.pickB   = 1'b1;
      end
      OP_CLRQ: begin
        ctrl.wrY     = 1'b0;
        ctrl.wrFlags = 1'b0;
        ctrl.condClr = 1'b1;
      end
      default: ;
    endcase
  end

  AST_CLR_DROPS_OP: assert property (@(posedge clk) clr |=> !ctrl.valid); // R10

  AST_LIVE_AFTER_RUN: assert property (@(posedge clk) disable iff (clr)
    !clr |=> ctrl.valid); // R9

endmodule

// File: rtl/pipe_alu_dp.sv
module pipe_alu_dp
  import pipe_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [DW-1:0] aIn,
  input  logic [DW-1:0] bIn,
  input  aluCtrl_t      ctrl,
  output logic [DW-1:0] yOut,
  output logic          cOut,
  output logic          vOut,
  output logic          zOut
);

  localparam int SHW = $clog2(DW);
  localparam int PW  = 2 * DW;

  logic [DW-1:0] aQ, bQ;
  logic [DW-1:0] yQ;
  logic          cQ, vQ, zQ;

  // stage one: operand capture
  always_ff @(posedge clk) begin
    if (clr) begin
      aQ <= '0;
      bQ <= '0;
    end else begin
      aQ <= aIn;
      bQ <= bIn;
    end
  end

  // shared adder for add, subtract, compare, increment, decrement
  logic [DW-1:0] addL, addR, addend;
  logic [DW:0]   sum;
  logic          addCarry, addOvf;

  always_comb begin
    addL     = ctrl.pickB ? bQ : aQ;
    addR     = ctrl.addOne ? DW'(1) : bQ;
    addend   = ctrl.subMode ? ~addR : addR;
    sum      = {1'b0, addL} + {1'b0, addend} + {{DW{1'b0}}, ctrl.subMode};
    addCarry = ctrl.subMode ? ~sum[DW] : sum[DW];
    addOvf   = (addL[DW-1] == addend[DW-1]) && (sum[DW-1] != addL[DW-1]);
  end

  // multiplier
  logic [PW-1:0] prod;
  assign prod = aQ * bQ;

  // barrel rotators, one stage per bit of the distance
  logic [SHW-1:0] amt;
  logic [DW-1:0]  rolStage [SHW+1];
  logic [DW-1:0]  rorStage [SHW+1];

  assign amt         = bQ[SHW-1:0];
  assign rolStage[0] = aQ;
  assign rorStage[0] = aQ;

  for (genvar k = 0; k < SHW; k++) begin : g_rot
    localparam int K = 1 << k;
    assign rolStage[k+1] = amt[k] ?
      {rolStage[k][DW-1-K:0], rolStage[k][DW-1:DW-K]} : rolStage[k];
    assign rorStage[k+1] = amt[k] ?
      {rorStage[k][K-1:0], rorStage[k][DW-1:K]} : rorStage[k];
  end

  // outcome selection
  logic [DW-1:0] res;
  logic          cNext, vNext;

  always_comb begin
    res   = '0;
    cNext = 1'b0;
    vNext = 1'b0;
    if (ctrl.arith) begin
      res   = sum[DW-1:0];
      cNext = addCarry;
      vNext = addOvf;
    end else begin
      unique case (ctrl.op)
        OP_MUL: begin
          res   = prod[DW-1:0];
          cNext = |prod[PW-1:DW];
        end
        OP_ROL:  res = rolStage[SHW];
        OP_ROR:  res = rorStage[SHW];
        OP_AND:  res = aQ & bQ;
        OP_OR:   res = aQ | bQ;
        OP_XOR:  res = aQ ^ bQ;
        OP_CPLA: res = ~aQ;
        OP_CPLB: res = ~bQ;
        default: res = '0;
      endcase
    end
  end

  logic operandsEqual;
  assign operandsEqual = (aQ == bQ);

  // stage two: result and flag registers
  always_ff @(posedge clk) begin
    if (clr) begin
      yQ <= '0;
      cQ <= 1'b0;
      vQ <= 1'b0;
      zQ <= 1'b0;
    end else if (ctrl.valid) begin
      if (ctrl.wrY) yQ <= res;
      if (ctrl.wrFlags) begin
        cQ <= cNext;
        vQ <= vNext;
        zQ <= (res == '0);
      end
      if (ctrl.condClr && operandsEqual) begin
        yQ <= '0;
        cQ <= 1'b0;
        vQ <= 1'b0;
        zQ <= 1'b1;
      end
    end
  end

  assign yOut = yQ;
  assign cOut = cQ;
  assign vOut = vQ;
  assign zOut = zQ;

  AST_CLR_ZEROES_OUT: assert property (@(posedge clk)
    clr |=> (yQ == '0) && !cQ && !vQ && !zQ); // R10

  AST_CMP_KEEPS_Y: assert property (@(posedge clk) disable iff (clr)
    (ctrl.valid && ctrl.op == OP_CMP) |=> $stable(yQ)); // R3

  AST_MUL_NO_OVF: assert property (@(posedge clk) disable iff (clr)
    (ctrl.valid && ctrl.op == OP_MUL) |=> !vQ); // R4

  AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (clr)
    (ctrl.valid && ctrl.op inside {OP_ROL, OP_ROR, OP_AND, OP_OR, OP_XOR, OP_CPLA, OP_CPLB})
    |=> !cQ && !vQ); // R6

  AST_Z_TRACKS_Y: assert property (@(posedge clk) disable iff (clr)
    (ctrl.valid && ctrl.wrY) |=> (zQ == (yQ == '0))); // R7

  AST_UNEQUAL_HOLDS: assert property (@(posedge clk) disable iff (clr)
    (ctrl.valid && ctrl.condClr && aQ != bQ) |=> $stable({yQ, cQ, vQ, zQ})); // R8

  AST_EQUAL_CLEARS: assert property (@(posedge clk) disable iff (clr)
    (ctrl.valid && ctrl.condClr && aQ == bQ) |=> (yQ == '0) && zQ && !cQ && !vQ); // R8

endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_alu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           clr,
  input  logic [DW-1:0]  opA,
  input  logic [DW-1:0]  opB,
  input  logic [OPW-1:0] opSel,
  output logic [DW-1:0]  result,
  output logic           carry,
  output logic           overflow,
  output logic           zero
);

  aluCtrl_t ctrl;

  pipe_alu_ctrl #(.OPW(OPW)) i_ctrl (
    .clk  (clk),
    .clr  (clr),
    .opIn (opSel),
    .ctrl (ctrl)
  );

  pipe_alu_dp #(.DW(DW)) i_dp (
    .clk  (clk),
    .clr  (clr),
    .aIn  (opA),
    .bIn  (opB),
    .ctrl (ctrl),
    .yOut (result),
    .cOut (carry),
    .vOut (overflow),
    .zOut (zero)
  );

endmodule

// File: tb/test_pipe_alu.sv
`timescale 1ns/1ps
module test_pipe_alu;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [3:0] opSel = '0;
  logic [7:0] result;
  logic       carry, overflow, zero;

  always #5 clk = ~clk;

  pipe_alu i_pipe_alu (
    .clk(clk), .clr(clr), .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .carry(carry), .overflow(overflow), .zero(zero)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int expY = 0;
  bit expC = 0, expV = 0, expZ = 0;

  bit d1Valid = 0, d2Valid = 0;
  int d1Op, d1A, d1B, d2Op, d2A, d2B;

  function automatic string reqOf(input int op);
    case (op)
      0, 3:            return "R1";
      1, 2, 8, 9:      return "R2";
      4:               return "R3";
      10:              return "R4";
      5, 6:            return "R5";
      7:               return "R8";
      default:         return "R6";
    endcase
  endfunction

  task automatic arithModel(input int x, input int y, input bit sub, input bit writeY);
    int r;
    if (!sub) begin
      r    = x + y;
      expC = (r > 255);
      r    = r % 256;
      expV = ((x >= 128) == (y >= 128)) && ((r >= 128) != (x >= 128));
    end else begin
      expC = (x < y);
      r    = (x - y + 256) % 256;
      expV = ((x >= 128) != (y >= 128)) && ((r >= 128) != (x >= 128));
    end
    expZ = (r == 0);
    if (writeY) expY = r;
  endtask

  task automatic plainModel(input int r);
    expY = r % 256;
    expC = 0;
    expV = 0;
    expZ = (expY == 0);
  endtask

  task automatic modelStep(input int op, input int a, input int b);
    int n, p;
    n = b % 8;
    case (op)
      0:  arithModel(a, b, 0, 1);
      1:  arithModel(a, 1, 0, 1);
      2:  arithModel(b, 1, 0, 1);
      3:  arithModel(a, b, 1, 1);
      4:  arithModel(a, b, 1, 0);
      5:  plainModel(((a << n) | (a >> (8 - n))) % 256);
      6:  plainModel(((a >> n) | (a << (8 - n))) % 256);
      7:  if (a == b) begin expY = 0; expC = 0; expV = 0; expZ = 1; end
      8:  arithModel(a, 1, 1, 1);
      9:  arithModel(b, 1, 1, 1);
      10: begin
        p = a * b;
        expY = p % 256;
        expC = (p / 256) != 0;
        expV = 0;
        expZ = (expY == 0);
      end
      11: plainModel(255 - a);
      12: plainModel(a & b);
      13: plainModel(a | b);
      14: plainModel(a ^ b);
      default: plainModel(255 - b);
    endcase
  endtask

  task automatic checkOut(input string tag);
    checks++;
    if (result !== 8'(expY) || carry !== expC || overflow !== expV || zero !== expZ) begin
      fails++;
      $display("FAIL %s%s: got y=%h c=%b v=%b z=%b expected y=%h c=%b v=%b z=%b",
               tag, (zero !== expZ) ? "/R7" : "", result, carry, overflow, zero,
               8'(expY), expC, expV, expZ);
    end
  endtask

  // one negedge: check the op issued two negedges ago, then drive the next
  task automatic issue(input bit isNew, input int op, input int a, input int b);
    @(negedge clk);
    if (d2Valid) begin
      modelStep(d2Op, d2A, d2B);
      checkOut({reqOf(d2Op), "/R9"});
    end
    d2Valid = d1Valid; d2Op = d1Op; d2A = d1A; d2B = d1B;
    d1Valid = isNew;   d1Op = op;   d1A = a;   d1B = b;
    opA = 8'(a); opB = 8'(b); opSel = 4'(op);
  endtask

  function automatic int bPick(input int i, input int a);
    case (i)
      0: return 0;
      1: return 1;
      2: return 127;
      3: return 128;
      4: return 255;
      5: return a;
      6: return 8'h0B;
      7: return 8'hF5;
      default: return (a * 37 + 11) % 256;
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // R10: reset state while clr is held
    repeat (3) @(negedge clk);
    expY = 0; expC = 0; expV = 0; expZ = 0;
    checkOut("R10 reset");

    // sweep: all opcodes, all A, nine B values (R1-related ops through R8)
    clr = 1'b0;
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 9; bi++)
          issue(1'b1, op, a, bPick(bi, a));
    issue(1'b0, 4, 0, 0);
    issue(1'b0, 4, 0, 0);

    // R10: clear collides with an add that completes on the same edge
    @(negedge clk);
    clr = 1'b0; opSel = 4'd0; opA = 8'd3; opB = 8'd4;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    expY = 0; expC = 0; expV = 0; expZ = 0;
    checkOut("R10 clear wins");
    clr = 1'b0; opSel = 4'd0; opA = 8'd1; opB = 8'd2;
    @(negedge clk);
    checkOut("R9 latency not yet");
    opSel = 4'd4; opA = 8'd5; opB = 8'd5;
    @(negedge clk);
    expY = 3; expC = 0; expV = 0; expZ = 0;
    checkOut("R9 latency result");
    @(negedge clk);
    expY = 3; expC = 0; expV = 0; expZ = 1;
    checkOut("R3 compare keeps y");

    finishRun();
  end

endmodule